// File: doc/BRIEF.md
# Single-Wire Half-Duplex Serial Transceiver with Parity-Error Signalling

This block is an asynchronous serial transceiver for a smart-card style link. Transmit and receive share one open-drain wire. The transmitter's frames therefore come back to its own receiver, and the far end's frames arrive on the same wire. A programmable divider runs from a selectable count source and makes a 16x oversampling tick. A one-byte holding buffer feeds a transmit shift register. The receiver oversamples the wire and captures each byte into a receive buffer.

When the receiver finds a parity error in a frame sent by the far end, it pulls the wire low for the stop-bit slot, so the sender learns of the error. The receiver does not do this for echoes of its own frames. When the transmitter sends a frame and the far end pulls the stop slot low, a readable flag records it.

Software uses a small register bus with write and read strobes. The transmit interrupt can be raised on holding-buffer empty or on shift-register empty. The receive interrupt is raised on each completed frame. Both requests clear on an acknowledge input or when software writes 0 to the request bit.

Top module: `uhd_sim_uart`

## Requirements
- R1: One bit lasts 16*(n+1) count-source cycles. n is the divider register (address 1). The count source is picked by CTRL[5:4]: 0 is the clock, 1 is the clock divided by PS_MID, and 2 or 3 is the clock divided by PS_SLOW.
- R2: On `ser_out`, a frame is a low start bit, data bits D0 to D7 in that order, a parity bit and a high stop bit. The parity bit is the XOR of the data for even parity (CTRL[2]=0) and its complement for odd parity (CTRL[2]=1). The line idles high.
- R3: A write to TXBUF (address 2) clears buffer-empty (STAT[0]). The frame does not start at once: it starts at the next bit boundary of the free-running bit clock, within one bit period. Buffer-empty sets again when the byte moves into the shift register.
- R4: Shift-empty (STAT[1]) is low from the start bit until exactly 11 bit periods later, the end of the stop bit. A byte already waiting is sent straight after, with no idle gap and with shift-empty staying low.
- R5: CTRL[3] chooses the transmit request. With 0, `tx_irq` rises when the byte leaves the buffer. With 1, `tx_irq` rises only when the shift register goes empty.
- R6: A received frame puts its byte in RXBUF (address 3) and sets receive-done (STAT[2]) and `rx_irq`. A read strobe on RXBUF clears receive-done.
- R7: A frame from the far end with wrong parity sets STAT[3] and makes `ser_out` low in the middle of the stop slot. A frame with correct parity clears STAT[3] and leaves the stop slot high.
- R8: While the transmitter is busy, parity errors on the echoed frame are ignored: STAT[3] stays 0 and the stop slot is not driven. STAT[4] records whether the stop slot was seen low.
- R9: The IRQ register (address 5) holds `tx_irq` in bit 0 and `rx_irq` in bit 1. Writing 0 to a bit clears that request, and writing 1 has no effect. `tx_ack` and `rx_ack` also clear their requests. A new request event wins over a clear in the same cycle.
- R10: CTRL[0] enables transmit. If it is cleared after a frame has started, that frame still finishes, and a byte waiting in the buffer is held until transmit is enabled again. CTRL[1] enables receive, and while it is 0 no frame is taken in.
- R11: After reset, `ser_out` is high, both requests are low, CTRL reads 0 and STAT reads 8'h03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on RXBUF only) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from addr) |
| tx_ack | input | 1 | Accept of the transmit request |
| rx_ack | input | 1 | Accept of the receive request |
| ser_in | input | 1 | Level of the shared wire |
| ser_out | output | 1 | Drive level onto the wire (0 pulls low, 1 releases) |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench sets PS_MID to 2 and PS_SLOW to 4, and uses divider values of 0 to 2. A bit then lasts 16 to 192 clocks, so every count-source setting can be decoded in a few thousand cycles. This makes frame-exact timing checks affordable for shift-empty, back-to-back frames, the stop-slot pull and the disable in mid-frame. The bench models the wire as the AND of `ser_out` and its own far-end driver. This lets it corrupt the parity or stop slot of echoed frames.

// File: rtl/uhd_pkg.sv
package uhd_pkg;
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_DIV   = 3'd1;
  localparam logic [2:0] A_TXBUF = 3'd2;
  localparam logic [2:0] A_RXBUF = 3'd3;
  localparam logic [2:0] A_STAT  = 3'd4;
  localparam logic [2:0] A_IRQ   = 3'd5;

  localparam int FRAME_BITS = 11;

  typedef enum logic [1:0] {RX_IDLE, RX_RUN, RX_TAIL} rx_st_t;

  // parity bit for a byte: even -> XOR of data, odd -> its complement
  function automatic logic par_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // frame as sent LSB first: start, D0..D7, parity, stop
  function automatic logic [FRAME_BITS-1:0] frame_of(input logic [7:0] d, input logic odd);
    return {1'b1, par_of(d, odd), d, 1'b0};
  endfunction
endpackage

// File: rtl/uhd_brg.sv
module uhd_brg #(
  parameter int DIV_W   = 8,
  parameter int PS_MID  = 8,
  parameter int PS_SLOW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);
  localparam int PSW = $clog2(PS_SLOW) + 1;

  logic [PSW-1:0]   ps_cnt;
  logic [PSW-1:0]   ps_lim;
  logic             src_en;
  logic [DIV_W-1:0] brg_cnt;

  always_comb begin
    case (src_sel)
      2'd0:    ps_lim = '0;
      2'd1:    ps_lim = PSW'(PS_MID - 1);
      default: ps_lim = PSW'(PS_SLOW - 1);
    endcase
    src_en = (ps_cnt >= ps_lim);
    tick   = src_en && (brg_cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_cnt  <= '0;
      brg_cnt <= '0;
    end else begin
      ps_cnt <= src_en ? '0 : ps_cnt + 1'b1;
      if (src_en) brg_cnt <= tick ? div_n : brg_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/uhd_tx.sv
module uhd_tx import uhd_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       tx_en,
  input  logic       parity_odd,
  input  logic       buf_wr,
  input  logic [7:0] buf_data,
  output logic       line,
  output logic       buf_empty,
  output logic       reg_empty,
  output logic       ev_load,
  output logic       ev_idle
);
  logic [3:0]            sub;
  logic [FRAME_BITS-1:0] sh;
  logic [3:0]            left;
  logic                  busy;
  logic [7:0]            hold;
  logic                  bempty;
  logic                  bit_tick;
  logic                  can_load;

  assign bit_tick = tick && (sub == 4'hF);
  assign can_load = tx_en && !bempty && (!busy || left == 4'd0);
  assign ev_load  = bit_tick && can_load;
  assign ev_idle  = bit_tick && busy && (left == 4'd0) && !can_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub    <= '0;
      sh     <= '1;
      left   <= '0;
      busy   <= 1'b0;
      hold   <= '0;
      bempty <= 1'b1;
    end else begin
      if (tick) sub <= sub + 1'b1;
      if (ev_load) begin
        sh     <= frame_of(hold, parity_odd);
        left   <= 4'(FRAME_BITS - 1);
        busy   <= 1'b1;
        bempty <= 1'b1;
      end else if (bit_tick && busy) begin
        if (left == 4'd0) busy <= 1'b0;
        else begin
          sh   <= {1'b1, sh[FRAME_BITS-1:1]};
          left <= left - 1'b1;
        end
      end
      if (buf_wr) begin
        hold   <= buf_data;
        bempty <= 1'b0;
      end
    end
  end

  assign line      = busy ? sh[0] : 1'b1;
  assign buf_empty = bempty;
  assign reg_empty = !busy;
endmodule

// File: rtl/uhd_rx.sv
module uhd_rx import uhd_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_en,
  input  logic       parity_odd,
  input  logic       line_in,
  input  logic       tx_busy,
  output logic       frame_done,
  output logic [7:0] data_q,
  output logic       perr_q,
  output logic       stop_low_q,
  output logic       drive_low
);
  logic       s1, s2, s3;
  rx_st_t     st;
  logic [3:0] sub;
  logic [3:0] idx;
  logic [7:0] shd;
  logic       errp;
  logic       fall;
  logic       mid;

  assign fall       = s3 && !s2;
  assign mid        = (st == RX_RUN) && tick && (sub == 4'd7);
  assign frame_done = mid && (idx == 4'(FRAME_BITS - 1));
  assign drive_low  = errp && ((st == RX_RUN && idx == 4'(FRAME_BITS - 1)) || st == RX_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
      st <= RX_IDLE;
      sub <= '0; idx <= '0; shd <= '0; errp <= 1'b0;
      data_q <= '0; perr_q <= 1'b0; stop_low_q <= 1'b0;
    end else begin
      s1 <= line_in; s2 <= s1; s3 <= s2;
      case (st)
        RX_IDLE: if (rx_en && fall) begin
          st <= RX_RUN; sub <= '0; idx <= '0; errp <= 1'b0;
        end
        RX_RUN: if (tick) begin
          sub <= sub + 1'b1;
          if (sub == 4'hF) idx <= idx + 1'b1;
          if (sub == 4'd7) begin
            if (idx == 4'd0) begin
              if (s2) st <= RX_IDLE;
            end else if (idx <= 4'd8) begin
              shd <= {s2, shd[7:1]};
            end else if (idx == 4'd9) begin
              errp <= (s2 != par_of(shd, parity_odd)) && !tx_busy;
            end else begin
              data_q     <= shd;
              perr_q     <= errp;
              stop_low_q <= !s2;
              st         <= errp ? RX_TAIL : RX_IDLE;
            end
          end
        end
        default: if (tick) begin
          sub <= sub + 1'b1;
          if (sub == 4'd14) begin
            st   <= RX_IDLE;
            errp <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/uhd_sim_uart.sv
module uhd_sim_uart import uhd_pkg::*; #(
  parameter int DIV_W   = 8,
  parameter int PS_MID  = 8,
  parameter int PS_SLOW = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tx_ack,
  input  logic       rx_ack,
  input  logic       ser_in,
  output logic       ser_out,
  output logic       tx_irq,
  output logic       rx_irq
);
  logic [5:0]       ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic             tick;
  logic             tx_line, tx_buf_empty, tx_reg_empty, ev_load, ev_idle;
  logic             frame_done, rx_perr, rx_stop_low, rx_drive;
  logic [7:0]       rx_data;
  logic             rx_done_q, tx_irq_q, rx_irq_q;
  logic             tx_en, rx_en, parity_odd, irq_cause, tx_busy;
  logic             wr_tx, rd_rx, wr_irq, tx_set;

  assign tx_en      = ctrl_q[0];
  assign rx_en      = ctrl_q[1];
  assign parity_odd = ctrl_q[2];
  assign irq_cause  = ctrl_q[3];
  assign tx_busy    = !tx_reg_empty;
  assign wr_tx      = wr_en && (addr == A_TXBUF);
  assign rd_rx      = rd_en && (addr == A_RXBUF);
  assign wr_irq     = wr_en && (addr == A_IRQ);
  assign tx_set     = irq_cause ? ev_idle : ev_load;

  uhd_brg #(.DIV_W(DIV_W), .PS_MID(PS_MID), .PS_SLOW(PS_SLOW)) i_brg (
    .clk(clk), .rst_n(rst_n), .src_sel(ctrl_q[5:4]), .div_n(div_q), .tick(tick)
  );

  uhd_tx i_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .parity_odd(parity_odd),
    .buf_wr(wr_tx), .buf_data(wdata), .line(tx_line), .buf_empty(tx_buf_empty),
    .reg_empty(tx_reg_empty), .ev_load(ev_load), .ev_idle(ev_idle)
  );

  uhd_rx i_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en), .parity_odd(parity_odd),
    .line_in(ser_in), .tx_busy(tx_busy), .frame_done(frame_done), .data_q(rx_data),
    .perr_q(rx_perr), .stop_low_q(rx_stop_low), .drive_low(rx_drive)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      div_q     <= '0;
      rx_done_q <= 1'b0;
      tx_irq_q  <= 1'b0;
      rx_irq_q  <= 1'b0;
    end else begin
      if (wr_en && addr == A_CTRL) ctrl_q <= wdata[5:0];
      if (wr_en && addr == A_DIV)  div_q  <= DIV_W'(wdata);
      if (frame_done)  rx_done_q <= 1'b1;
      else if (rd_rx)  rx_done_q <= 1'b0;
      if (tx_set) tx_irq_q <= 1'b1;
      else if (tx_ack || (wr_irq && !wdata[0])) tx_irq_q <= 1'b0;
      if (frame_done) rx_irq_q <= 1'b1;
      else if (rx_ack || (wr_irq && !wdata[1])) rx_irq_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {2'b00, ctrl_q};
      A_DIV:   rdata = 8'(div_q);
      A_RXBUF: rdata = rx_data;
      A_STAT:  rdata = {3'b000, rx_stop_low, rx_perr, rx_done_q, tx_reg_empty, tx_buf_empty};
      A_IRQ:   rdata = {6'b0, rx_irq_q, tx_irq_q};
      default: rdata = '0;
    endcase
  end

  assign ser_out = tx_line && !rx_drive;
  assign tx_irq  = tx_irq_q;
  assign rx_irq  = rx_irq_q;
endmodule

// File: rtl/uhd_chk.sv
module uhd_chk import uhd_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [2:0] addr,
  input logic       ser_out,
  input logic       tx_irq,
  input logic       tx_ack,
  input logic       ev_load,
  input logic       ev_idle,
  input logic       irq_cause,
  input logic       tx_busy,
  input logic       tx_buf_empty,
  input logic       rx_drive,
  input logic       frame_done,
  input logic       rx_done_q
);
  // R2
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !rx_drive) |-> ser_out);

  // R3
  buf_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load && !(wr_en && addr == A_TXBUF)) |=> tx_buf_empty);

  // R4
  shift_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> tx_busy);

  // R5
  tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cause ? ev_idle : ev_load) |=> tx_irq);

  // R6
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_RXBUF && !frame_done) |=> !rx_done_q);

  // R9
  tx_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ack && !ev_load && !ev_idle) |=> !tx_irq);
endmodule

bind uhd_sim_uart uhd_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .ser_out(ser_out), .tx_irq(tx_irq), .tx_ack(tx_ack), .ev_load(ev_load),
  .ev_idle(ev_idle), .irq_cause(irq_cause), .tx_busy(tx_busy),
  .tx_buf_empty(tx_buf_empty), .rx_drive(rx_drive), .frame_done(frame_done),
  .rx_done_q(rx_done_q)
);

// File: tb/test_uhd_sim_uart.sv
module test_uhd_sim_uart;
  localparam int PS_MID  = 2;
  localparam int PS_SLOW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, tx_ack = 1'b0, rx_ack = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ser_in, ser_out, tx_irq, rx_irq;
  logic       far = 1'b1;

  int checks = 0;
  int errors = 0;
  int bitclk = 32;

  always #10 clk = ~clk;
  assign ser_in = ser_out & far;

  uhd_sim_uart #(.DIV_W(8), .PS_MID(PS_MID), .PS_SLOW(PS_SLOW)) i_uhd_sim_uart (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tx_ack(tx_ack), .rx_ack(rx_ack), .ser_in(ser_in), .ser_out(ser_out),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  function automatic logic ref_par(input logic [7:0] d, input logic odd);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    return logic'(ones % 2) ^ odd;
  endfunction

  function automatic logic [10:0] ref_frame(input logic [7:0] d, input logic odd);
    logic [10:0] f;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) f[i+1] = d[i];
    f[9] = ref_par(d, odd);
    f[10] = 1'b1;
    return f;
  endfunction

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic set_cfg(input int n, input int sel, input logic odd, input logic cause,
                         input logic txe, input logic rxe);
    bus_wr(3'd1, 8'(n));
    bus_wr(3'd0, {2'b00, 2'(sel), cause, odd, rxe, txe});
    bitclk = 16 * (n + 1) * (sel == 0 ? 1 : (sel == 1 ? PS_MID : PS_SLOW));
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    while (ser_out !== 1'b0 && n < 100000) begin @(negedge clk); n++; end
  endtask

  task automatic sample_frame(input int lag, output logic [10:0] b);
    repeat (bitclk / 2 - lag) @(negedge clk);
    b[0] = ser_out;
    for (int i = 1; i < 11; i++) begin
      repeat (bitclk) @(negedge clk);
      b[i] = ser_out;
    end
  endtask

  task automatic wait_shift_empty(output int n);
    logic [7:0] s;
    n = 0;
    peek(3'd4, s);
    while (!s[1] && n < 100000) begin @(negedge clk); n++; peek(3'd4, s); end
  endtask

  task automatic far_send(input logic [7:0] d, input logic odd, input logic bad,
                          output logic stop_lvl);
    logic [10:0] f;
    f = ref_frame(d, odd);
    if (bad) f[9] = ~f[9];
    for (int i = 0; i < 11; i++) begin
      far = f[i];
      if (i == 10) begin
        repeat (bitclk / 2) @(negedge clk);
        stop_lvl = ser_out;
        repeat (bitclk - bitclk / 2) @(negedge clk);
      end else repeat (bitclk) @(negedge clk);
    end
    far = 1'b1;
  endtask

  task automatic loopback(input logic [7:0] d, input logic odd, input string tag);
    logic [10:0] b;
    logic [7:0]  r;
    int          n;
    bus_wr(3'd2, d);
    wait_fall(n);
    sample_frame(0, b);
    chk_eq({tag, " R2 frame"}, b, ref_frame(d, odd));
    wait_shift_empty(n);
    bus_rd(3'd3, r);
    chk_eq({tag, " R6 rxbuf"}, r, d);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements): actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  s, r;
    logic [10:0] b;
    logic        lvl, mn;
    int          n;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk_eq("R11 ser_out", ser_out, 1);
    peek(3'd4, s); chk_eq("R11 stat", s, 8'h03);
    peek(3'd0, s); chk_eq("R11 ctrl", s, 0);
    chk_eq("R11 irqs", {tx_irq, rx_irq}, 0);

    // R3 deferred start, R5 cause 0, R2 frame, R6 receive
    set_cfg(1, 0, 1'b0, 1'b0, 1'b1, 1'b1);
    bus_wr(3'd2, 8'hA5);
    chk_eq("R3 no immediate start", ser_out, 1);
    peek(3'd4, s); chk_eq("R3 buffer full after write", s[0], 0);
    wait_fall(n);
    chk_eq("R3 start within one bit", int'(n >= 1 && n <= bitclk), 1);
    peek(3'd4, s);
    chk_eq("R3 buffer empty at load", s[0], 1);
    chk_eq("R4 shift busy", s[1], 0);
    chk_eq("R5 cause0 irq at load", tx_irq, 1);
    sample_frame(0, b);
    chk_eq("R2 frame A5 even", b, ref_frame(8'hA5, 1'b0));
    wait_shift_empty(n);
    peek(3'd4, s); chk_eq("R6 rx done set", s[2], 1);
    chk_eq("R6 rx irq", rx_irq, 1);
    chk_eq("R8 own frame no perr", s[3], 0);
    bus_rd(3'd3, r); chk_eq("R6 rxbuf", r, 8'hA5);
    peek(3'd4, s); chk_eq("R6 rx done cleared", s[2], 0);

    // R9 clears
    bus_wr(3'd5, 8'h02);
    chk_eq("R9 tx cleared by write 0", tx_irq, 0);
    chk_eq("R9 rx kept by write 1", rx_irq, 1);
    @(negedge clk); rx_ack = 1'b1; @(negedge clk); rx_ack = 1'b0;
    chk_eq("R9 rx cleared by ack", rx_irq, 0);

    // R5 cause 1, R4 exact shift-empty timing
    set_cfg(1, 0, 1'b1, 1'b1, 1'b1, 1'b1);
    bus_wr(3'd2, 8'h3C);
    wait_fall(n);
    n = 0; mn = 1'b0;
    peek(3'd4, s);
    while (!s[1] && n < 100000) begin
      @(negedge clk); n++;
      if (n == 5 * bitclk) mn = tx_irq;
      peek(3'd4, s);
    end
    chk_eq("R5 cause1 no irq mid frame", mn, 0);
    chk_eq("R4 shift empty after 11 bits", n, 11 * bitclk);
    chk_eq("R5 cause1 irq at shift empty", tx_irq, 1);
    @(negedge clk); tx_ack = 1'b1; @(negedge clk); tx_ack = 1'b0;
    chk_eq("R9 tx cleared by ack", tx_irq, 0);
    bus_rd(3'd3, r); chk_eq("R6 rxbuf odd", r, 8'h3C);

    // R4 back-to-back
    bus_wr(3'd2, 8'h81);
    wait_fall(n);
    bus_wr(3'd2, 8'h7E);
    sample_frame(2, b);
    chk_eq("R4 first frame", b, ref_frame(8'h81, 1'b1));
    wait_fall(n);
    chk_eq("R4 no idle gap", n, bitclk / 2);
    peek(3'd4, s); chk_eq("R4 shift busy across frames", s[1], 0);
    sample_frame(0, b);
    chk_eq("R4 second frame", b, ref_frame(8'h7E, 1'b1));
    wait_shift_empty(n);
    bus_rd(3'd3, r); chk_eq("R6 rxbuf last", r, 8'h7E);

    // R7 far-end parity error and good frame
    set_cfg(1, 0, 1'b0, 1'b0, 1'b1, 1'b1);
    far_send(8'h5A, 1'b0, 1'b1, lvl);
    chk_eq("R7 stop pulled low", lvl, 0);
    repeat (bitclk) @(negedge clk);
    peek(3'd4, s); chk_eq("R7 perr set", s[3], 1);
    bus_rd(3'd3, r); chk_eq("R7 rxbuf", r, 8'h5A);
    far_send(8'hC3, 1'b0, 1'b0, lvl);
    chk_eq("R7 good stop high", lvl, 1);
    repeat (bitclk) @(negedge clk);
    peek(3'd4, s); chk_eq("R7 perr cleared", s[3], 0);

    // R8 echoed frame: parity slot corrupted -> ignored
    bus_wr(3'd2, 8'h01);
    wait_fall(n);
    repeat (9 * bitclk + bitclk / 4) @(negedge clk);
    far = 1'b0;
    repeat (bitclk / 2) @(negedge clk);
    far = 1'b1;
    repeat (bitclk - bitclk / 2 - bitclk / 4) @(negedge clk);
    chk_eq("R8 no drive on own frame", ser_out, 1);
    wait_shift_empty(n);
    peek(3'd4, s);
    chk_eq("R8 perr ignored", s[3], 0);
    chk_eq("R8 stop seen high", s[4], 0);
    // R8 far end pulls stop slot
    bus_wr(3'd2, 8'h10);
    wait_fall(n);
    repeat (10 * bitclk + bitclk / 4) @(negedge clk);
    far = 1'b0;
    repeat (bitclk / 2) @(negedge clk);
    far = 1'b1;
    wait_shift_empty(n);
    peek(3'd4, s); chk_eq("R8 stop low recorded", s[4], 1);
    bus_rd(3'd3, r);

    // R10 transmit disable mid frame
    bus_wr(3'd2, 8'h96);
    wait_fall(n);
    bus_wr(3'd2, 8'h69);
    bus_wr(3'd0, 8'h02);
    sample_frame(4, b);
    chk_eq("R10 started frame finishes", b, ref_frame(8'h96, 1'b0));
    mn = 1'b1;
    for (int i = 0; i < 4 * bitclk; i++) begin @(negedge clk); mn &= ser_out; end
    chk_eq("R10 line idle after disable", mn, 1);
    peek(3'd4, s); chk_eq("R10 byte held", s[0], 0);
    bus_rd(3'd3, r);
    bus_wr(3'd5, 8'h00);
    bus_wr(3'd0, 8'h00);
    far_send(8'h44, 1'b0, 1'b0, lvl);
    repeat (bitclk) @(negedge clk);
    peek(3'd4, s); chk_eq("R10 rx disabled no frame", s[2], 0);
    chk_eq("R10 rx disabled no irq", rx_irq, 0);
    bus_wr(3'd0, 8'h03);
    wait_fall(n);
    sample_frame(0, b);
    chk_eq("R10 held byte sent", b, ref_frame(8'h69, 1'b0));
    wait_shift_empty(n);
    bus_rd(3'd3, r);

    // R1 count-source selections
    set_cfg(0, 1, 1'b0, 1'b0, 1'b1, 1'b1);
    loopback(8'hE7, 1'b0, "R1 sel1");
    bus_wr(3'd2, 8'h00);
    wait_fall(n); wait_shift_empty(n);
    chk_eq("R1 sel1 period", n, 11 * bitclk);
    bus_rd(3'd3, r);
    set_cfg(2, 2, 1'b1, 1'b0, 1'b1, 1'b1);
    loopback(8'h2B, 1'b1, "R1 sel2");
    bus_wr(3'd2, 8'hFF);
    wait_fall(n); wait_shift_empty(n);
    chk_eq("R1 sel2 period", n, 11 * bitclk);
    bus_rd(3'd3, r);

    // R1 R2 R6 random loopback
    for (int k = 0; k < 10; k++) begin
      logic [7:0] d;
      logic       odd;
      int         dv;
      d = 8'($urandom);
      odd = 1'($urandom);
      dv = int'($urandom % 3);
      set_cfg(dv, 0, odd, 1'b0, 1'b1, 1'b1);
      loopback(d, odd, "R1 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule